// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory bus. It holds a 512-byte array split into two 256-byte halves. A page bit carried in the device-address byte picks the half. The block samples SCL and SDA on its own system clock. It finds start and stop conditions and decodes the device-address byte against a fixed family code and two board-strapped select pins. It acknowledges on an open-drain SDA by driving a single drive-low enable.

A master can store one byte or a run of bytes. A run of writes wraps inside a 16-byte page. The master can also read from any location by first sending a dummy write that loads the word address. A read can instead continue from the internal address pointer with no word address sent. The pointer keeps its value from one transaction to the next, so a master that knows where the last access ended can read onward from there.

Top module: `eeprom_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the 9th SCL clock) only when the device-address bits 7..4 equal 1010 and bits 3..2 equal the `hw_sel[1:0]` pins. Bits are sent MSB first, and bit 0 is read(1)/write(0).
- R2: On a device address that does not match, the slave gives no acknowledge and ignores all further bytes until the next start condition. Writes sent in that time leave the memory unchanged.
- R3: A write takes bit 1 of the device byte as page bit P0. The next byte is the word address, and the following data byte is stored at {P0, word address}.
- R4: Each further data byte in one write transaction goes to the next location. Only the low 4 address bits advance, so the page index and P0 stay fixed and the run wraps within a 16-byte page.
- R5: A write of the device address and word address, followed by a repeated start and a read device address, returns the byte at that location.
- R6: On a read with no word address, the P0 bit in the device byte has no effect. The stored pointer, including its page bit, picks the byte.
- R7: During reads the pointer advances by one at the SCL falling edge that ends the 8th data bit. It keeps its value across transactions.
- R8: If the master acknowledges a read byte, the slave sends the next byte. Reads roll over from location 511 to location 0.
- R9: After a read byte that the master does not acknowledge, the slave leaves SDA released. A stop returns it to idle with SDA released.
- R10: A start condition (SDA falling while SCL is high) restarts device-address reception, even in the middle of a byte.
- R11: The slave changes its SDA drive only while SCL is low. Out of reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock from the master |
| sda_in | input | 1 | Resolved level of the SDA line |
| hw_sel | input | 2 | Strapped select pins compared with device-address bits 3..2 |
| sda_drive_low | output | 1 | When high, the slave pulls SDA low |

## Verification
The bench builds the block with its defaults: a 4-bit in-page counter and the 1010 family code. With those values the in-page wrap from word 0x2F back to 0x20 is in reach, as is the read rollover from the top of the upper half (0x1FF) to location 0 of the lower half. The bench also changes the select pins mid-run, so both the matching and non-matching select paths are exercised. Restarts issued partway through a byte show that a start overrides the bit counter.

// File: rtl/eeprom_slave.sv
module eeprom_slave #(
  parameter int PAGE_AW = 4,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda_in,
  input  logic [1:0] hw_sel,
  output logic       sda_drive_low
);
  localparam int WORD_W = 8;
  localparam int MEM_AW = WORD_W + 1;
  localparam int DEPTH  = 1 << MEM_AW;

  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_WADR = 3'd2,
                         S_WDAT = 3'd3, S_RDAT = 3'd4, S_IGN = 3'd5;

  logic [7:0]        mem [DEPTH];
  logic [2:0]        scl_sh, sda_sh;
  logic [2:0]        state;
  logic [3:0]        cnt;
  logic              ack_slot, rd_go, page_bit, m_ack, drive;
  logic [7:0]        rx_sr, tx_sr;
  logic [MEM_AW-1:0] ptr;

  wire scl_s = scl_sh[1];
  wire scl_p = scl_sh[2];
  wire sda_s = sda_sh[1];
  wire sda_p = sda_sh[2];

  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  wire dev_match = (rx_sr[7:4] == DEV_ID) && (rx_sr[3:2] == hw_sel);
  wire byte_done = scl_fall && (cnt == 4'd8) && !ack_slot;
  wire mem_we    = !start_det && !stop_det && (state == S_WDAT) && byte_done;
  wire [7:0] rd_byte = mem[ptr];

  assign sda_drive_low = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl};
      sda_sh <= {sda_sh[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= rx_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ack_slot <= 1'b0;
      rd_go    <= 1'b0;
      page_bit <= 1'b0;
      m_ack    <= 1'b0;
      drive    <= 1'b0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      ptr      <= '0;
    end else if (start_det) begin
      state    <= S_DEV;
      cnt      <= '0;
      ack_slot <= 1'b0;
      drive    <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ack_slot <= 1'b0;
      drive    <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise && !ack_slot && cnt != 4'd8) begin
            rx_sr <= {rx_sr[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            ack_slot <= 1'b1;
            case (state)
              S_DEV: begin
                if (dev_match) begin
                  drive <= 1'b1;
                  rd_go <= rx_sr[0];
                  if (!rx_sr[0]) page_bit <= rx_sr[1];
                end else begin
                  state    <= S_IGN;
                  ack_slot <= 1'b0;
                end
              end
              S_WADR: begin
                ptr   <= {page_bit, rx_sr};
                drive <= 1'b1;
              end
              default: begin
                ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + {{(PAGE_AW-1){1'b0}}, 1'b1};
                drive <= 1'b1;
              end
            endcase
          end else if (scl_fall && ack_slot) begin
            ack_slot <= 1'b0;
            cnt      <= '0;
            drive    <= 1'b0;
            if (state == S_DEV) begin
              if (rd_go) begin
                state <= S_RDAT;
                tx_sr <= rd_byte;
                drive <= ~rd_byte[7];
              end else begin
                state <= S_WADR;
              end
            end else begin
              state <= S_WDAT;
            end
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            if (!ack_slot) cnt <= cnt + 4'd1;
            else m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (!ack_slot) begin
              if (cnt == 4'd8) begin
                ptr      <= ptr + 9'd1;
                drive    <= 1'b0;
                ack_slot <= 1'b1;
              end else begin
                tx_sr <= {tx_sr[6:0], 1'b0};
                drive <= ~tx_sr[6];
              end
            end else begin
              ack_slot <= 1'b0;
              cnt      <= '0;
              if (m_ack) begin
                tx_sr <= rd_byte;
                drive <= ~rd_byte[7];
              end else begin
                state <= S_IGN;
                drive <= 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk #(
  parameter int PAGE_AW = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic [2:0] state,
  input logic       mem_we,
  input logic [8:0] ptr,
  input logic       drive
);
  localparam logic [2:0] C_IDLE = 3'd0, C_DEV = 3'd1, C_RDAT = 3'd4, C_IGN = 3'd5;

  // R11
  drive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> !scl_s);

  // R10
  start_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == C_DEV && !drive));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == C_IDLE && !drive));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IGN) |-> !drive);

  // R4
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr[8:PAGE_AW] == $past(ptr[8:PAGE_AW])));

  // R7
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_RDAT && $past(state) == C_RDAT && ptr != $past(ptr))
      |-> (ptr == 9'($past(ptr) + 9'd1)));
endmodule

bind eeprom_slave eeprom_slave_chk #(.PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .state(state), .mem_we(mem_we), .ptr(ptr),
  .drive(sda_drive_low)
);

// File: tb/test_eeprom_slave.sv
`timescale 1ns/1ps
module test_eeprom_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, scl_m, sda_m_low, drv;
  logic [1:0] hw_sel, cur_sel;
  wire        sda_bus = ~(sda_m_low | drv);

  eeprom_slave i_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(sda_bus),
    .hw_sel(hw_sel), .sda_drive_low(drv)
  );

  int checks = 0, fails = 0, viol = 0;
  bit done = 0;
  typedef struct { logic [7:0] v; string r; } exp_t;
  exp_t exp_q[$];
  logic [7:0] obs;
  event obs_ev;

  task automatic chk(bit ok, string r, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  task automatic push(logic [7:0] v, string r);
    exp_t e;
    e.v = v; e.r = r;
    exp_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) chk(1'b0, "scoreboard empty", obs, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(obs === e.v, e.r, obs, e.v);
      end
    end
  end

  logic prev_drv = 1'b0;
  always @(negedge clk) begin
    if (rst_n && drv !== prev_drv && scl_m) viol++;
    prev_drv = drv;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m_low = 1'b0; wq(); scl_m = 1'b1; wq();
    sda_m_low = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m_low = 1'b0; wq();
  endtask

  task automatic send_bit(logic b);
    sda_m_low = ~b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_m_low = 1'b0; wq(); scl_m = 1'b1; wq();
    ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic sb(logic [7:0] v, logic exp_ack, string r);
    logic a;
    send_byte(v, a);
    chk(a === exp_ack, r, a, exp_ack);
  endtask

  task automatic recv_byte(logic give_ack);
    logic [7:0] v;
    logic line;
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); v[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m_low = give_ack; wq(); scl_m = 1'b1; wq();
    line = sda_bus; wq(); scl_m = 1'b0; sda_m_low = 1'b0; wq();
    if (!give_ack) chk(line === 1'b1, "R9 released after nack", line, 1);
    obs = v;
    ->obs_ev;
    #1;
  endtask

  function automatic logic [7:0] devb(logic [1:0] s, logic p0, logic rw);
    return {4'b1010, s, p0, rw};
  endfunction

  task automatic wr(logic p0, logic [7:0] word, logic [7:0] d);
    bus_start();
    sb(devb(cur_sel, p0, 1'b0), 1'b1, "R1 dev ack");
    sb(word, 1'b1, "R3 word ack");
    sb(d, 1'b1, "R3 data ack");
    bus_stop();
  endtask

  task automatic rr(logic p0, logic [7:0] word, int n);
    bus_start();
    sb(devb(cur_sel, p0, 1'b0), 1'b1, "R5 dev ack");
    sb(word, 1'b1, "R5 word ack");
    bus_start();
    sb(devb(cur_sel, p0, 1'b1), 1'b1, "R5 read ack");
    for (int k = 0; k < n; k++) recv_byte(k < n - 1);
    bus_stop();
  endtask

  task automatic rc(logic p0, int n);
    bus_start();
    sb(devb(cur_sel, p0, 1'b1), 1'b1, "R6 read ack");
    for (int k = 0; k < n; k++) recv_byte(k < n - 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m_low = 1'b0; hw_sel = 2'b00; cur_sel = 2'b00;
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    wq();
    chk(drv === 1'b0, "R11 reset released", drv, 0);

    // R3 and R5: both halves, random read
    wr(1'b0, 8'h10, 8'hA5);
    wr(1'b1, 8'h10, 8'h5A);
    push(8'hA5, "R5 random read low half");
    rr(1'b0, 8'h10, 1);
    push(8'h5A, "R3 upper half");
    rr(1'b1, 8'h10, 1);

    // R4 page wrap
    wr(1'b1, 8'h21, 8'h99);
    bus_start();
    sb(devb(cur_sel, 1'b0, 1'b0), 1'b1, "R4 dev ack");
    sb(8'h2E, 1'b1, "R4 word ack");
    sb(8'h11, 1'b1, "R4 data ack");
    sb(8'h22, 1'b1, "R4 data ack");
    sb(8'h33, 1'b1, "R4 data ack");
    sb(8'h44, 1'b1, "R4 data ack");
    sb(8'h66, 1'b1, "R4 data ack");
    bus_stop();
    push(8'h33, "R4 wrapped to 0x20");
    rr(1'b0, 8'h20, 1);
    // R6: pointer now 0x021; P0=1 in device byte must not select 0x121
    push(8'h44, "R6 stored pointer used");
    rc(1'b1, 1);
    push(8'h66, "R7 pointer persists");
    rc(1'b0, 1);
    push(8'h11, "R4 page start");
    push(8'h22, "R4 page next");
    rr(1'b0, 8'h2E, 2);

    // R8 rollover
    wr(1'b1, 8'hFF, 8'hC3);
    wr(1'b0, 8'h00, 8'h3C);
    push(8'hC3, "R8 top byte");
    push(8'h3C, "R8 rollover to 0");
    rr(1'b1, 8'hFF, 2);

    // R2 mismatch
    bus_start();
    sb(devb(2'b11, 1'b0, 1'b0), 1'b0, "R2 select mismatch nack");
    sb(8'h10, 1'b0, "R2 ignored word");
    sb(8'hEE, 1'b0, "R2 ignored data");
    bus_stop();
    bus_start();
    sb(8'b0110_0000, 1'b0, "R2 family mismatch nack");
    bus_stop();
    push(8'hA5, "R2 memory unchanged");
    rr(1'b0, 8'h10, 1);
    chk(drv === 1'b0, "R9 idle after stop", drv, 0);

    // R1 select pins
    hw_sel = 2'b10; cur_sel = 2'b10;
    wq();
    wr(1'b0, 8'h50, 8'h42);
    push(8'h42, "R1 new select");
    rr(1'b0, 8'h50, 1);
    bus_start();
    sb(devb(2'b00, 1'b0, 1'b1), 1'b0, "R1 old select nack");
    bus_stop();

    // R10 restart mid-byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    push(8'hA5, "R10 restart mid-byte");
    rr(1'b0, 8'h10, 1);

    chk(viol == 0, "R11 drive change while SCL high", viol, 0);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule